// File: doc/BRIEF.md
# Cycle-Stepped 8-bit Processor Subset Core

This block is a small accumulator-style 8-bit processor core that runs a short list of opcodes with exact, defined bus behaviour in every clock cycle. On each cycle it presents a 16-bit address, a read/write strobe and, for writes, a data byte. It samples an 8-bit read-data bus at the end of the cycle. The memory is expected to return read data within the same cycle and to capture write data at the closing clock edge. The core holds a program counter, an accumulator, two index registers, a stack pointer, a status byte and an opcode register. A one-hot timing register steps through the cycles of each opcode.

After reset the core reads a two-byte start vector and then begins fetching. It can fetch an opcode and run the following: the three immediate loads, absolute load and store of the accumulator, the index-to-stack-pointer transfer, push accumulator and pull status. Every stack access goes to page 0x01. An opcode outside this set stops the core, which stays halted until the next reset. The status byte is driven out so that a system can see it.

Top module: `byte_seq_core`

## Requirements
- R1: While `rst_n` is low, the core shows address 0xFFFC with the read strobe at 1, `halted_o` at 0 and `status_o` at 0x00. Reset also clears the accumulator, both index registers, the stack pointer and the opcode register. A store or push made right after reset therefore writes 0x00, and a push made right after reset writes at 0x0100.
- R2: After reset is released, the core reads 0xFFFC and then 0xFFFD. On the next cycle it fetches from the address whose low byte came from 0xFFFC and whose high byte came from 0xFFFD.
- R3: The cycle after an opcode fetch at address F is a read at F+1, and the opcode register takes the fetched byte.
- R4: The immediate loads take two cycles each: 0xA9 loads the accumulator, 0xA2 loads X and 0xA0 loads Y, each from the byte read at F+1. The next fetch is at F+2.
- R5: The absolute load 0xAD reads its low address byte at F+1 and its high address byte at F+2. It then reads at {high, low} and loads the accumulator from that byte. The next fetch is at F+3, four cycles after the opcode fetch.
- R6: The absolute store 0x8D reads its address bytes at F+1 and F+2. In its fourth cycle it writes the accumulator to {high, low} with the read strobe at 0. Exactly one write cycle occurs, and the next fetch is at F+3.
- R7: Opcode 0x9A copies X into the stack pointer. Its second cycle reads at F+1, and the next fetch is at that same address F+1.
- R8: Opcode 0x28 runs for five cycles. The bus shows the fetch, two reads at F+1, a read at 0x0100+S and a read at 0x0100+S+1. The core then fetches at F+1. `status_o` takes the byte read at 0x0100+S+1, and the stack pointer ends at S+1.
- R9: Opcode 0x48 runs for three cycles. The bus shows the fetch, a dummy read at F+1, and a write of the accumulator at 0x0100+S. The core then fetches at F+1. The stack pointer ends at S-1 and wraps from 0x00 to 0xFF.
- R10: For any other opcode, the cycle after the opcode's second cycle shows `halted_o` at 1 with the read strobe at 1. The address stays frozen until reset, and reset clears the halt.
- R11: The timing register is one-hot and returns to its first step at every fetch. Consecutive opcodes therefore follow each other with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_o | output | 16 | Address of this cycle's memory access |
| bus_wdata_o | output | 8 | Byte to store when the strobe is 0 |
| bus_rd_o | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_rdata_i | input | 8 | Byte returned by memory for a read cycle |
| status_o | output | 8 | Current status byte |
| halted_o | output | 1 | Sticky stop after an unsupported opcode |

## Verification
Two functions can coincide on the bus: a store's write cycle and the fetch that follows it. A program stores the accumulator into the byte that is fetched next, where that byte was first seeded with an unsupported opcode. The fetch must return the new byte and run it as a load of X, rather than halt. This is judged by the later push address, which shows the value that was loaded. The wrap of the stack pointer is provoked in the same way, by pushing twice from S=0x00. The two writes must land at 0x0100 and then at 0x01FF.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   // Opcode values that the core recognises
   localparam logic [7:0] OPC_LDA_IMM = 8'hA9;
   localparam logic [7:0] OPC_LDX_IMM = 8'hA2;
   localparam logic [7:0] OPC_LDY_IMM = 8'hA0;
   localparam logic [7:0] OPC_LDA_ABS = 8'hAD;
   localparam logic [7:0] OPC_STA_ABS = 8'h8D;
   localparam logic [7:0] OPC_TXS     = 8'h9A;
   localparam logic [7:0] OPC_PHA     = 8'h48;
   localparam logic [7:0] OPC_PLP     = 8'h28;

   typedef enum logic [3:0] {
      OPK_LDA_IMM,
      OPK_LDX_IMM,
      OPK_LDY_IMM,
      OPK_LDA_ABS,
      OPK_STA_ABS,
      OPK_TXS,
      OPK_PHA,
      OPK_PLP,
      OPK_BAD
   } op_kind_t;

   typedef enum logic [1:0] {
      BOOT_VLO,
      BOOT_VHI,
      BOOT_RUN,
      BOOT_HALT
   } boot_t;

endpackage

// File: rtl/bsc_op_decode.sv
module bsc_op_decode
   import bsc_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode_i,
   output op_kind_t         kind_o
);

   if (OPC_W != 8) begin : g_bad_width
      $error("bsc_op_decode: opcode width must be 8");
   end

   always_comb begin
      unique case (opcode_i)
         OPC_LDA_IMM: kind_o = OPK_LDA_IMM;
         OPC_LDX_IMM: kind_o = OPK_LDX_IMM;
         OPC_LDY_IMM: kind_o = OPK_LDY_IMM;
         OPC_LDA_ABS: kind_o = OPK_LDA_ABS;
         OPC_STA_ABS: kind_o = OPK_STA_ABS;
         OPC_TXS:     kind_o = OPK_TXS;
         OPC_PHA:     kind_o = OPK_PHA;
         OPC_PLP:     kind_o = OPK_PLP;
         default:     kind_o = OPK_BAD;
      endcase
   end

endmodule

// File: rtl/bsc_tstate_ring.sv
module bsc_tstate_ring #(
   parameter int N_STEPS = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance_i,
   input  logic               restart_i,
   output logic [N_STEPS-1:0] step_o
);

   localparam int LAST_USED = 5;
   localparam logic [N_STEPS-1:0] FIRST = N_STEPS'(1);

   if (N_STEPS < LAST_USED + 1) begin : g_too_short
      $error("bsc_tstate_ring: at least six timing steps are required");
   end

   logic [N_STEPS-1:0] shifted;
   assign shifted = {step_o[N_STEPS-2:0], 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n)         step_o <= FIRST;
      else if (restart_i) step_o <= FIRST;
      else if (advance_i) step_o <= shifted;
   end

   // R11: exactly one timing step is active at all times
   p_step_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(step_o) == 1);

   // R11: a fetch returns the ring to its first step
   p_restart_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> step_o[0]);

   // R11: no opcode runs past its fifth step
   p_no_late_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      step_o[N_STEPS-1:LAST_USED] == '0);

endmodule

// File: rtl/byte_seq_core.sv
module byte_seq_core
   import bsc_pkg::*;
#(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter int                N_STEPS    = 7,
   parameter logic [ADDR_W-1:0] VECTOR_LO  = 16'hFFFC,
   parameter logic [7:0]        STACK_PAGE = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              bus_rd_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic              halted_o
);

   localparam int                PAGE_W    = ADDR_W - DATA_W;
   localparam logic [ADDR_W-1:0] VECTOR_HI = VECTOR_LO + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);
   localparam logic [DATA_W-1:0] ONE_D     = DATA_W'(1);

   if (DATA_W != 8) begin : g_bad_data
      $error("byte_seq_core: data width must be 8");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("byte_seq_core: address width must be twice the data width");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q, xr_q, yr_q, sp_q, ir_q, tmp_lo_q;
   boot_t             boot_q;
   logic [N_STEPS-1:0] step;
   op_kind_t          kind;
   logic              adv_now, fetch_now, halt_now;
   logic [ADDR_W-1:0] pc_inc, stack_addr, abs_addr;

   assign pc_inc     = pc_q + ONE_A;
   assign stack_addr = {PAGE_W'(STACK_PAGE), sp_q};
   assign abs_addr   = {bus_rdata_i, tmp_lo_q};
   assign halted_o   = (boot_q == BOOT_HALT);

   bsc_op_decode #(.OPC_W(DATA_W)) u_decode (
      .opcode_i (ir_q),
      .kind_o   (kind)
   );

   bsc_tstate_ring #(.N_STEPS(N_STEPS)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (adv_now),
      .restart_i (fetch_now),
      .step_o    (step)
   );

   // Step control: which opcode step ends with a fetch
   always_comb begin
      adv_now   = 1'b0;
      fetch_now = 1'b0;
      halt_now  = 1'b0;
      if (boot_q == BOOT_RUN) begin
         if (step[0]) begin
            adv_now = 1'b1;
         end else begin
            unique case (kind)
               OPK_LDA_IMM, OPK_LDX_IMM, OPK_LDY_IMM, OPK_TXS:
                  fetch_now = step[1];
               OPK_LDA_ABS, OPK_STA_ABS: begin
                  adv_now   = step[1] | step[2];
                  fetch_now = step[3];
               end
               OPK_PHA: begin
                  adv_now   = step[1];
                  fetch_now = step[2];
               end
               OPK_PLP: begin
                  adv_now   = step[1] | step[2] | step[3];
                  fetch_now = step[4];
               end
               default: halt_now = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q        <= '0;
         acc_q       <= '0;
         xr_q        <= '0;
         yr_q        <= '0;
         sp_q        <= '0;
         status_o    <= '0;
         ir_q        <= '0;
         tmp_lo_q    <= '0;
         bus_addr_o  <= VECTOR_LO;
         bus_wdata_o <= '0;
         bus_rd_o    <= 1'b1;
         boot_q      <= BOOT_VLO;
      end else begin
         unique case (boot_q)
            BOOT_VLO: begin
               tmp_lo_q   <= bus_rdata_i;
               bus_addr_o <= VECTOR_HI;
               boot_q     <= BOOT_VHI;
            end
            BOOT_VHI: begin
               pc_q       <= abs_addr;
               bus_addr_o <= abs_addr;
               boot_q     <= BOOT_RUN;
            end
            BOOT_RUN: begin
               if (halt_now) begin
                  bus_rd_o <= 1'b1;
                  boot_q   <= BOOT_HALT;
               end else if (step[0]) begin
                  ir_q       <= bus_rdata_i;
                  pc_q       <= pc_inc;
                  bus_addr_o <= pc_inc;
                  bus_rd_o   <= 1'b1;
               end else begin
                  unique case (kind)
                     OPK_LDA_IMM, OPK_LDX_IMM, OPK_LDY_IMM: begin
                        if (kind == OPK_LDA_IMM) acc_q <= bus_rdata_i;
                        if (kind == OPK_LDX_IMM) xr_q  <= bus_rdata_i;
                        if (kind == OPK_LDY_IMM) yr_q  <= bus_rdata_i;
                        pc_q       <= pc_inc;
                        bus_addr_o <= pc_inc;
                        bus_rd_o   <= 1'b1;
                     end
                     OPK_LDA_ABS, OPK_STA_ABS: begin
                        if (step[1]) begin
                           tmp_lo_q   <= bus_rdata_i;
                           pc_q       <= pc_inc;
                           bus_addr_o <= pc_inc;
                        end else if (step[2]) begin
                           pc_q       <= pc_inc;
                           bus_addr_o <= abs_addr;
                           if (kind == OPK_STA_ABS) begin
                              bus_wdata_o <= acc_q;
                              bus_rd_o    <= 1'b0;
                           end
                        end else begin
                           if (kind == OPK_LDA_ABS) acc_q <= bus_rdata_i;
                           bus_addr_o <= pc_q;
                           bus_rd_o   <= 1'b1;
                        end
                     end
                     OPK_TXS: begin
                        sp_q       <= xr_q;
                        bus_addr_o <= pc_q;
                     end
                     OPK_PHA: begin
                        if (step[1]) begin
                           bus_addr_o  <= stack_addr;
                           bus_wdata_o <= acc_q;
                           bus_rd_o    <= 1'b0;
                           sp_q        <= sp_q - ONE_D;
                        end else begin
                           bus_addr_o <= pc_q;
                           bus_rd_o   <= 1'b1;
                        end
                     end
                     OPK_PLP: begin
                        if (step[2]) begin
                           bus_addr_o <= stack_addr;
                           sp_q       <= sp_q + ONE_D;
                        end else if (step[3]) begin
                           bus_addr_o <= stack_addr;
                        end else if (step[4]) begin
                           status_o   <= bus_rdata_i;
                           bus_addr_o <= pc_q;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end

   // R2: the second vector read follows the first
   p_vector_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q == BOOT_VLO) |=> (bus_addr_o == VECTOR_HI) && bus_rd_o);

   // R3: an opcode fetch is followed by a read of the next byte
   p_fetch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q == BOOT_RUN && step[0]) |=>
         (bus_addr_o == $past(bus_addr_o) + ONE_A) && bus_rd_o);

   // R4: Y takes the immediate byte
   p_ldy_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_q == BOOT_RUN && kind == OPK_LDY_IMM && step[1]) |=>
         yr_q == $past(bus_rdata_i));

   // R6: a write cycle never lasts longer than one clock
   p_single_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_o |=> bus_rd_o);

   // R9: a push writes inside the stack page
   p_push_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_o && kind == OPK_PHA) |-> bus_addr_o[ADDR_W-1:DATA_W] == PAGE_W'(STACK_PAGE));

   // R10: a halt is sticky and freezes the bus in read mode
   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |=> halted_o && bus_rd_o && $stable(bus_addr_o));

endmodule

// File: tb/tb_byte_seq_core.sv
module tb_byte_seq_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_rd;
   logic [7:0]  bus_rdata;
   logic [7:0]  status;
   logic        halted;

   int checks = 0;
   int fails  = 0;

   logic [7:0] mem [0:2047];

   always #10 clk = ~clk;

   byte_seq_core dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_o  (bus_addr),
      .bus_wdata_o (bus_wdata),
      .bus_rd_o    (bus_rd),
      .bus_rdata_i (bus_rdata),
      .status_o    (status),
      .halted_o    (halted)
   );

   assign bus_rdata = mem[bus_addr[10:0]];

   always @(posedge clk) begin
      if (rst_n && !bus_rd) mem[bus_addr[10:0]] <= bus_wdata;
   end

   task automatic poke(input logic [15:0] a, input logic [7:0] d);
      mem[a[10:0]] = d;
   endtask

   task automatic check_bus(input string tag, input logic [15:0] ea,
                            input logic er, input logic [7:0] ed);
      @(negedge clk);
      checks++;
      if (bus_addr !== ea || bus_rd !== er || (!er && bus_wdata !== ed) || halted !== 1'b0) begin
         fails++;
         $display("FAIL %s: addr=%h rd=%b wd=%h halt=%b expected addr=%h rd=%b wd=%h halt=0",
                  tag, bus_addr, bus_rd, bus_wdata, halted, ea, er, ed);
      end
   endtask

   task automatic check_halt(input string tag, input logic [15:0] ea);
      @(negedge clk);
      checks++;
      if (halted !== 1'b1 || bus_rd !== 1'b1 || bus_addr !== ea) begin
         fails++;
         $display("FAIL %s: halt=%b rd=%b addr=%h expected halt=1 rd=1 addr=%h",
                  tag, halted, bus_rd, bus_addr, ea);
      end
   endtask

   task automatic check_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [15:0] vec);
      poke(16'hFFFC, vec[7:0]);
      poke(16'hFFFD, vec[15:8]);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (bus_addr !== 16'hFFFC || bus_rd !== 1'b1 || halted !== 1'b0 || status !== 8'h00) begin
         fails++;
         $display("FAIL R1/R10 reset: addr=%h rd=%b halt=%b status=%h expected addr=fffc rd=1 halt=0 status=00",
                  bus_addr, bus_rd, halted, status);
      end
      rst_n = 1'b1;
   endtask

   // Immediates, store, transfer, push, pull, halt
   task automatic t_mixed_program();
      poke(16'h0200, 8'hA9); poke(16'h0201, 8'h5A);
      poke(16'h0202, 8'h8D); poke(16'h0203, 8'h00); poke(16'h0204, 8'h03);
      poke(16'h0205, 8'hA2); poke(16'h0206, 8'h33);
      poke(16'h0207, 8'hA0); poke(16'h0208, 8'h77);
      poke(16'h0209, 8'h9A);
      poke(16'h020A, 8'h48);
      poke(16'h020B, 8'h48);
      poke(16'h020C, 8'h28);
      poke(16'h020D, 8'hFF);
      poke(16'h0300, 8'h00);
      do_reset(16'h0200);
      check_bus("R2 vector hi", 16'hFFFD, 1'b1, 8'h00);
      check_bus("R2 first fetch", 16'h0200, 1'b1, 8'h00);
      check_bus("R3 after fetch", 16'h0201, 1'b1, 8'h00);
      check_bus("R4 lda imm next fetch", 16'h0202, 1'b1, 8'h00);
      check_bus("R6 lo byte", 16'h0203, 1'b1, 8'h00);
      check_bus("R6 hi byte", 16'h0204, 1'b1, 8'h00);
      check_bus("R6 store cycle", 16'h0300, 1'b0, 8'h5A);
      check_bus("R11 fetch after store", 16'h0205, 1'b1, 8'h00);
      check_val("R6 stored byte", mem[11'h300], 8'h5A);
      check_bus("R3 ldx operand", 16'h0206, 1'b1, 8'h00);
      check_bus("R4 ldy fetch", 16'h0207, 1'b1, 8'h00);
      check_bus("R4 ldy operand", 16'h0208, 1'b1, 8'h00);
      check_bus("R4 txs fetch", 16'h0209, 1'b1, 8'h00);
      check_bus("R7 txs second", 16'h020A, 1'b1, 8'h00);
      check_bus("R7 fetch same addr", 16'h020A, 1'b1, 8'h00);
      check_bus("R9 dummy read", 16'h020B, 1'b1, 8'h00);
      check_bus("R7 push at X", 16'h0133, 1'b0, 8'h5A);
      check_bus("R9 fetch after push", 16'h020B, 1'b1, 8'h00);
      check_bus("R9 dummy read 2", 16'h020C, 1'b1, 8'h00);
      check_bus("R9 push decremented", 16'h0132, 1'b0, 8'h5A);
      check_bus("R11 fetch plp", 16'h020C, 1'b1, 8'h00);
      check_bus("R8 idle 1", 16'h020D, 1'b1, 8'h00);
      check_bus("R8 idle 2", 16'h020D, 1'b1, 8'h00);
      check_bus("R8 stack read S", 16'h0131, 1'b1, 8'h00);
      check_bus("R8 stack read S+1", 16'h0132, 1'b1, 8'h00);
      check_bus("R8 fetch after pull", 16'h020D, 1'b1, 8'h00);
      check_val("R8 status loaded", status, 8'h5A);
      check_bus("R10 bad op second cycle", 16'h020E, 1'b1, 8'h00);
      check_halt("R10 halted", 16'h020E);
      repeat (3) @(negedge clk);
      check_halt("R10 still halted", 16'h020E);
   endtask

   // Absolute load, zero transfer, stack wrap
   task automatic t_load_and_wrap();
      poke(16'h0350, 8'hC3);
      poke(16'h0400, 8'hAD); poke(16'h0401, 8'h50); poke(16'h0402, 8'h03);
      poke(16'h0403, 8'hA2); poke(16'h0404, 8'h00);
      poke(16'h0405, 8'h9A);
      poke(16'h0406, 8'h48);
      poke(16'h0407, 8'h48);
      poke(16'h0408, 8'hFF);
      do_reset(16'h0400);
      check_bus("R2 vector hi", 16'hFFFD, 1'b1, 8'h00);
      check_bus("R2 fetch at vector", 16'h0400, 1'b1, 8'h00);
      check_bus("R5 lo byte", 16'h0401, 1'b1, 8'h00);
      check_bus("R5 hi byte", 16'h0402, 1'b1, 8'h00);
      check_bus("R5 data read", 16'h0350, 1'b1, 8'h00);
      check_bus("R5 fetch after load", 16'h0403, 1'b1, 8'h00);
      check_bus("R4 ldx operand", 16'h0404, 1'b1, 8'h00);
      check_bus("R11 txs fetch", 16'h0405, 1'b1, 8'h00);
      check_bus("R7 txs second", 16'h0406, 1'b1, 8'h00);
      check_bus("R7 fetch same addr", 16'h0406, 1'b1, 8'h00);
      check_bus("R9 dummy read", 16'h0407, 1'b1, 8'h00);
      check_bus("R5 loaded value pushed", 16'h0100, 1'b0, 8'hC3);
      check_bus("R9 fetch", 16'h0407, 1'b1, 8'h00);
      check_bus("R9 dummy read 2", 16'h0408, 1'b1, 8'h00);
      check_bus("R9 wrap to 01ff", 16'h01FF, 1'b0, 8'hC3);
      check_bus("R9 fetch bad op", 16'h0408, 1'b1, 8'h00);
      check_bus("R10 second cycle", 16'h0409, 1'b1, 8'h00);
      check_halt("R10 halted", 16'h0409);
   endtask

   // Reset after halt clears halt and registers
   task automatic t_reset_clears();
      poke(16'h0360, 8'hEE);
      poke(16'h0500, 8'h8D); poke(16'h0501, 8'h60); poke(16'h0502, 8'h03);
      poke(16'h0503, 8'h48);
      poke(16'h0504, 8'hFF);
      do_reset(16'h0500);
      check_bus("R2 vector hi", 16'hFFFD, 1'b1, 8'h00);
      check_bus("R2 fetch", 16'h0500, 1'b1, 8'h00);
      check_bus("R6 lo byte", 16'h0501, 1'b1, 8'h00);
      check_bus("R6 hi byte", 16'h0502, 1'b1, 8'h00);
      check_bus("R1 store of cleared A", 16'h0360, 1'b0, 8'h00);
      check_bus("R11 fetch push", 16'h0503, 1'b1, 8'h00);
      check_bus("R9 dummy read", 16'h0504, 1'b1, 8'h00);
      check_bus("R1 push at cleared S", 16'h0100, 1'b0, 8'h00);
      check_bus("R9 fetch", 16'h0504, 1'b1, 8'h00);
      check_bus("R10 second cycle", 16'h0505, 1'b1, 8'h00);
      check_halt("R10 halted", 16'h0505);
      check_val("R1 status after reset", status, 8'h00);
   endtask

   // Store into the next opcode byte, then fetch it
   task automatic t_self_modify();
      poke(16'h0600, 8'hA9); poke(16'h0601, 8'hA2);
      poke(16'h0602, 8'h8D); poke(16'h0603, 8'h05); poke(16'h0604, 8'h06);
      poke(16'h0605, 8'hFF);
      poke(16'h0606, 8'h55);
      poke(16'h0607, 8'h9A);
      poke(16'h0608, 8'h48);
      poke(16'h0609, 8'hFF);
      do_reset(16'h0600);
      check_bus("R2 vector hi", 16'hFFFD, 1'b1, 8'h00);
      check_bus("R2 fetch", 16'h0600, 1'b1, 8'h00);
      check_bus("R4 operand", 16'h0601, 1'b1, 8'h00);
      check_bus("R4 next fetch", 16'h0602, 1'b1, 8'h00);
      check_bus("R6 lo byte", 16'h0603, 1'b1, 8'h00);
      check_bus("R6 hi byte", 16'h0604, 1'b1, 8'h00);
      check_bus("R6 store into code", 16'h0605, 1'b0, 8'hA2);
      check_bus("R11 fetch stored op", 16'h0605, 1'b1, 8'h00);
      check_bus("R3 operand of new op", 16'h0606, 1'b1, 8'h00);
      check_bus("R4 txs fetch", 16'h0607, 1'b1, 8'h00);
      check_bus("R7 txs second", 16'h0608, 1'b1, 8'h00);
      check_bus("R7 push fetch", 16'h0608, 1'b1, 8'h00);
      check_bus("R9 dummy read", 16'h0609, 1'b1, 8'h00);
      check_bus("R7 push at loaded X", 16'h0155, 1'b0, 8'hA2);
      check_bus("R9 fetch", 16'h0609, 1'b1, 8'h00);
      check_val("R9 pushed byte", mem[11'h155], 8'hA2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R11 watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
      t_mixed_program();
      t_load_and_wrap();
      t_reset_clears();
      t_self_modify();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule